// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control side of a successive-approximation converter with a 14-bit result. A falling edge on the active-low start input begins a conversion. The block then holds a sample phase and runs a binary search over a 16-bit trial level. The 14 upper trial bits go to the main DAC, and the two lowest go to a fine correction DAC. An external comparator reports whether the input lies at or above each trial level.

After the sixteenth decision the block rounds the two correction bits into a 14-bit result. It then pulls the end-of-conversion flag low. A host reads the result most significant bit first on a serial line, gated by an active-low select and advanced by falling edges of a read clock that is slower than the conversion clock. Asserting reset stops everything. Releasing reset starts a calibration interval of fixed length. A two-bit mode input picks unipolar range, bipolar range (offset binary) or a power-down state in which start requests are refused.

Top module: `sar_conv_seq`

## Requirements
- R1: A start is taken only in the ready state, and only when `conv_n` is seen high on one `clk` edge and low on the next. The edge that takes the start drives `sample_o` high, and `sample_o` stays high for `SAMP_CYC` cycles.
- R2: The first trial after the sample phase is `{dac_code,dac_fine}` = 16'h8000 (only code bit d13 set, DAC at half of reference).
- R3: At each step a comparator value of 1 keeps the bit under trial and 0 clears it, and the next lower bit is then set. With an ideal comparator (`cmp_i` = trial level <= input), the final 16-bit trial equals the input level.
- R4: `eoc_n` falls on the `clk` edge that comes `SAMP_CYC`+16 edges after the start edge.
- R5: The result is min((raw16 + 2) >> 2, 16383), where raw16 is the final 16-bit trial.
- R6: `eoc_n` goes high on the start edge. It goes low at the finish and stays low until the next accepted start.
- R7: While `eoc_n` is low, `dout` shows the current result bit. The MSB is shown without any `sclk` activity, each synchronized falling edge of `sclk` (with `cs_n` low) moves to the next lower bit, and 0 follows the last bit. `dout` is 0 while `eoc_n` is high.
- R8: `dout_oe` equals the inverse of `cs_n`. Raising `cs_n` rewinds the readout, so the next read starts again from the MSB.
- R9: While `rst_n` is low, `eoc_n` is 1, `sample_o` is 0 and the trial code is 0. After release, calibration runs for `CAL_CYC` cycles. During calibration, start edges are ignored and `eoc_n` stays high.
- R10: With `mode` = 2'b00 or 2'b11 (power-down), the ready state refuses starts and `sleep_o` is 1. The previous result and the `eoc_n` level are kept.
- R11: `range_bip` is 1 for a conversion started with `mode` = 2'b10 and 0 for `mode` = 2'b01. It is captured at the start and held until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset; release starts calibration |
| conv_n | input | 1 | Active-low conversion start, synchronous to clk |
| mode | input | 2 | 00/11 power-down, 01 unipolar, 10 bipolar |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the trial level |
| cs_n | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial read clock, falling edge advances |
| dac_code | output | 14 | Main DAC trial code |
| dac_fine | output | 2 | Correction DAC trial bits below d0 |
| sample_o | output | 1 | High during the sample phase |
| range_bip | output | 1 | Bipolar range select for the analog side |
| sleep_o | output | 1 | Power-down indication while idle |
| eoc_n | output | 1 | Active-low end of conversion |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for dout |

## Verification
The edge that takes a start drives `sample_o` and `eoc_n` high. The first trial code appears `SAMP_CYC` edges later, and `eoc_n` falls after exactly `SAMP_CYC`+16 edges. The bench counts edges from the start edge and samples at the next falling clock edge. Serial bits pass through a two-stage synchronizer and an edge register before they advance. The bench therefore waits four conversion-clock cycles after each `sclk` fall or `cs_n` rise before it samples `dout`. `dout_oe` and the first MSB depend only on combinational paths, so they are checked just after `cs_n` falls.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_CAL = 2'd0,
    ST_RDY = 2'd1,
    ST_SMP = 2'd2,
    ST_CNV = 2'd3
  } seq_st_e;

  localparam logic [1:0] MD_SHDN = 2'b00;
  localparam logic [1:0] MD_UNI  = 2'b01;
  localparam logic [1:0] MD_BIP  = 2'b10;
  localparam logic [1:0] MD_OFF  = 2'b11;

  function automatic logic is_off(input logic [1:0] m);
    return (m == MD_SHDN) || (m == MD_OFF);
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int TW       = 16,
  parameter int SAMP_CYC = 2,
  parameter int CAL_CYC  = 32,
  parameter int IW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_n,
  input  logic [1:0]    mode,
  output logic          sample_o,
  output logic          ld_first_o,
  output logic          step_o,
  output logic          last_o,
  output logic [IW-1:0] idx_o,
  output logic          eoc_n_o,
  output logic          sleep_o,
  output logic          range_bip_o
);

  localparam int M1 = (CAL_CYC > SAMP_CYC) ? CAL_CYC : SAMP_CYC;
  localparam int M2 = (M1 > TW) ? M1 : TW;
  localparam int CW = $clog2(M2 + 1);
  localparam logic [CW-1:0] CAL_LAST  = CW'(CAL_CYC - 1);
  localparam logic [CW-1:0] SMP_LAST  = CW'(SAMP_CYC - 1);
  localparam logic [CW-1:0] STEP_LAST = CW'(TW - 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          eoc_q, eoc_d;
  logic          bip_q, bip_d;
  logic          conv_q;
  logic          conv_fall;
  logic          start;

  assign conv_fall = conv_q & ~conv_n;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    eoc_d = eoc_q;
    bip_d = bip_q;
    start = 1'b0;
    case (st_q)
      ST_CAL: begin
        if (cnt_q == CAL_LAST) begin
          st_d  = ST_RDY;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RDY: begin
        if (conv_fall && !is_off(mode)) begin
          start = 1'b1;
          st_d  = ST_SMP;
          cnt_d = '0;
          eoc_d = 1'b1;
          bip_d = (mode == MD_BIP);
        end
      end
      ST_SMP: begin
        if (cnt_q == SMP_LAST) begin
          st_d  = ST_CNV;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_CNV: begin
        if (cnt_q == STEP_LAST) begin
          st_d  = ST_RDY;
          cnt_d = '0;
          eoc_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_CAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_CAL;
      cnt_q  <= '0;
      eoc_q  <= 1'b1;
      bip_q  <= 1'b0;
      conv_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      eoc_q  <= eoc_d;
      bip_q  <= bip_d;
      conv_q <= conv_n;
    end
  end

  assign sample_o    = (st_q == ST_SMP);
  assign ld_first_o  = (st_q == ST_SMP) && (cnt_q == SMP_LAST);
  assign step_o      = (st_q == ST_CNV);
  assign last_o      = (st_q == ST_CNV) && (cnt_q == STEP_LAST);
  assign idx_o       = cnt_q[IW-1:0];
  assign eoc_n_o     = eoc_q;
  assign sleep_o     = (st_q == ST_RDY) && is_off(mode);
  assign range_bip_o = bip_q;

  // R6: a taken start raises eoc and enters the sample phase
  p_start_eoc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (eoc_q && sample_o));
  // R6: a finished conversion keeps eoc low until the next start
  p_eoc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc_q && !start) |=> !eoc_q);
  // R10: power-down refuses the sample phase
  p_shdn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RDY && is_off(mode)) |=> (st_q != ST_SMP));
  // R11: range is only captured when a start is taken
  p_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RDY) |=> $stable(bip_q));
  // R4: eoc cannot fall before the last step
  p_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CNV && cnt_q != STEP_LAST) |=> eoc_q);
  // R9: calibration leads only to the ready state
  p_cal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CAL) |=> (st_q == ST_CAL || st_q == ST_RDY));

endmodule

// File: rtl/sar_seq_trial.sv
module sar_seq_trial #(
  parameter int RES_W   = 14,
  parameter int EXTRA_W = 2,
  parameter int IW      = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_first_i,
  input  logic                       step_i,
  input  logic                       last_i,
  input  logic [IW-1:0]              idx_i,
  input  logic                       cmp_i,
  output logic [RES_W+EXTRA_W-1:0]   trial_o,
  output logic [RES_W-1:0]           res_o,
  output logic [RES_W-1:0]           res_nx_o
);

  localparam int TW = RES_W + EXTRA_W;
  localparam logic [TW-1:0] TOP_BIT  = {1'b1, {(TW-1){1'b0}}};
  localparam logic [TW:0]   HALF_LSB = (TW+1)'(1) << (EXTRA_W - 1);

  logic [TW-1:0]    tr_q, tr_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [IW-1:0]    pos;
  logic [TW:0]      rsum;

  always_comb begin
    tr_d  = '0;
    res_d = res_q;
    pos   = IW'(TW - 1) - idx_i;
    rsum  = '0;
    if (ld_first_i) begin
      tr_d = TOP_BIT;
    end else if (step_i) begin
      tr_d = tr_q;
      if (!cmp_i) tr_d[pos] = 1'b0;
      if (pos != '0) tr_d[pos - IW'(1)] = 1'b1;
      if (last_i) begin
        rsum  = {1'b0, tr_d} + HALF_LSB;
        res_d = rsum[TW] ? '1 : rsum[TW-1:EXTRA_W];
        tr_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tr_q  <= '0;
      res_q <= '0;
    end else begin
      tr_q  <= tr_d;
      res_q <= res_d;
    end
  end

  assign trial_o  = tr_q;
  assign res_o    = res_q;
  assign res_nx_o = res_d;

  // R2: the first trial after sampling is the top bit alone
  p_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_first_i |=> (tr_q == TOP_BIT));
  // R3: a low comparator lowers the trial level
  p_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !last_i && !cmp_i) |=> (tr_q < $past(tr_q)));
  // R3: a high comparator raises the trial level
  p_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !last_i && cmp_i) |=> (tr_q > $past(tr_q)));

endmodule

// File: rtl/sar_seq_rdout.sv
module sar_seq_rdout #(
  parameter int RES_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [RES_W-1:0] load_val_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             eoc_n_i,
  input  logic             cs_n,
  input  logic             sclk,
  output logic             dout,
  output logic             dout_oe
);

  logic [RES_W-1:0] sh_q, sh_d;
  logic sclk_s1, sclk_s2, sclk_p;
  logic cs_s1, cs_s2, cs_p;
  logic sclk_fall, cs_rise, shift_en;

  assign sclk_fall = sclk_p & ~sclk_s2;
  assign cs_rise   = cs_s2 & ~cs_p;
  assign shift_en  = sclk_fall & ~cs_s2 & ~eoc_n_i;

  always_comb begin
    sh_d = sh_q;
    if (load_i)        sh_d = load_val_i;
    else if (cs_rise)  sh_d = res_i;
    else if (shift_en) sh_d = {sh_q[RES_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      sclk_s1 <= 1'b0;
      sclk_s2 <= 1'b0;
      sclk_p  <= 1'b0;
      cs_s1   <= 1'b1;
      cs_s2   <= 1'b1;
      cs_p    <= 1'b1;
    end else begin
      sh_q    <= sh_d;
      sclk_s1 <= sclk;
      sclk_s2 <= sclk_s1;
      sclk_p  <= sclk_s2;
      cs_s1   <= cs_n;
      cs_s2   <= cs_s1;
      cs_p    <= cs_s2;
    end
  end

  assign dout    = ~eoc_n_i & sh_q[RES_W-1];
  assign dout_oe = ~cs_n;

  // R7: the finishing edge loads the fresh result
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (sh_q == $past(load_val_i)));
  // R7: a read-clock fall moves one bit onward
  p_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_i && !cs_rise) |=> (sh_q == {$past(sh_q[RES_W-2:0]), 1'b0}));
  // R8: deselect rewinds to the stored result
  p_rewind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !load_i) |=> (sh_q == $past(res_i)));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq #(
  parameter int RES_W    = 14,
  parameter int EXTRA_W  = 2,
  parameter int SAMP_CYC = 2,
  parameter int CAL_CYC  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               conv_n,
  input  logic [1:0]         mode,
  input  logic               cmp_i,
  input  logic               cs_n,
  input  logic               sclk,
  output logic [RES_W-1:0]   dac_code,
  output logic [EXTRA_W-1:0] dac_fine,
  output logic               sample_o,
  output logic               range_bip,
  output logic               sleep_o,
  output logic               eoc_n,
  output logic               dout,
  output logic               dout_oe
);

  localparam int TW = RES_W + EXTRA_W;
  localparam int IW = $clog2(TW);

  logic             rs1, rs_n;
  logic             ld_first, step, last;
  logic [IW-1:0]    idx;
  logic [TW-1:0]    trial;
  logic [RES_W-1:0] res, res_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1  <= 1'b0;
      rs_n <= 1'b0;
    end else begin
      rs1  <= 1'b1;
      rs_n <= rs1;
    end
  end

  sar_seq_ctrl #(
    .TW(TW), .SAMP_CYC(SAMP_CYC), .CAL_CYC(CAL_CYC), .IW(IW)
  ) u_ctrl (
    .clk(clk), .rst_n(rs_n), .conv_n(conv_n), .mode(mode),
    .sample_o(sample_o), .ld_first_o(ld_first), .step_o(step),
    .last_o(last), .idx_o(idx), .eoc_n_o(eoc_n), .sleep_o(sleep_o),
    .range_bip_o(range_bip)
  );

  sar_seq_trial #(
    .RES_W(RES_W), .EXTRA_W(EXTRA_W), .IW(IW)
  ) u_trial (
    .clk(clk), .rst_n(rs_n), .ld_first_i(ld_first), .step_i(step),
    .last_i(last), .idx_i(idx), .cmp_i(cmp_i), .trial_o(trial),
    .res_o(res), .res_nx_o(res_nx)
  );

  sar_seq_rdout #(
    .RES_W(RES_W)
  ) u_rdout (
    .clk(clk), .rst_n(rs_n), .load_i(last), .load_val_i(res_nx),
    .res_i(res), .eoc_n_i(eoc_n), .cs_n(cs_n), .sclk(sclk),
    .dout(dout), .dout_oe(dout_oe)
  );

  assign dac_code = trial[TW-1:EXTRA_W];
  assign dac_fine = trial[EXTRA_W-1:0];

endmodule

// File: tb/sim_sar_conv_seq.sv
`timescale 1ns/1ps
module sim_sar_conv_seq;
  localparam int RW = 14, XW = 2, TW = 16, SMP = 2, CAL = 32;

  logic clk = 1'b0, rst_n = 1'b0, conv_n = 1'b1, cs_n = 1'b1, sclk = 1'b0;
  logic [1:0] mode = 2'b01;
  logic cmp;
  logic [RW-1:0] dac_code;
  logic [XW-1:0] dac_fine;
  logic sample_o, range_bip, sleep_o, eoc_n, dout, dout_oe;
  logic [TW-1:0] vin = '0;
  int checks = 0, fails = 0;
  bit fin = 1'b0;
  logic [RW-1:0] exp_q[$];
  logic [RW-1:0] got_q[$];
  logic [RW-1:0] last_exp = '0;
  event got_ev;

  always #2.5 clk = ~clk;
  assign cmp = ({dac_code, dac_fine} <= vin);

  sar_conv_seq #(.RES_W(RW), .EXTRA_W(XW), .SAMP_CYC(SMP), .CAL_CYC(CAL)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_n(conv_n), .mode(mode), .cmp_i(cmp),
    .cs_n(cs_n), .sclk(sclk), .dac_code(dac_code), .dac_fine(dac_fine),
    .sample_o(sample_o), .range_bip(range_bip), .sleep_o(sleep_o),
    .eoc_n(eoc_n), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [RW-1:0] model(input logic [TW-1:0] v);
    logic [TW:0] s;
    s = {1'b0, v} + 17'd2;
    return s[TW] ? {RW{1'b1}} : s[TW-1:XW];
  endfunction

  // driver: start a conversion and push the expected word
  task automatic convert(input logic [TW-1:0] v, input logic [1:0] md, input logic [1:0] md_mid);
    int n;
    vin = v;
    mode = md;
    @(negedge clk) conv_n = 1'b0;
    @(posedge clk);
    @(negedge clk) conv_n = 1'b1;
    chk("R6 eoc high at start", eoc_n, 1);
    chk("R1 sample phase entered", sample_o, 1);
    chk("R11 range captured", range_bip, (md == 2'b10));
    last_exp = model(v);
    exp_q.push_back(last_exp);
    n = 0;
    while (eoc_n && n < 60) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == SMP - 1) chk("R1 sample held", sample_o, 1);
      if (n == SMP) chk("R2 first trial", {dac_code, dac_fine}, 32'h8000);
      if (n == 5) begin
        mode = md_mid;
        chk("R7 dout quiet while converting", dout, 0);
      end
      if (n == SMP + TW - 1) chk("R11 range held", range_bip, (md == 2'b10));
    end
    chk("R4 edges to finish", n, SMP + TW);
  endtask

  // serial read of one word; observed word goes to the monitor
  task automatic readout();
    logic [RW-1:0] got;
    @(negedge clk) cs_n = 1'b0;
    #1;
    chk("R8 oe on select", dout_oe, 1);
    for (int i = RW - 1; i >= 0; i--) begin
      got[i] = dout;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    chk("R7 zero after last bit", dout, 0);
    cs_n = 1'b1;
    #1;
    chk("R8 oe off on deselect", dout_oe, 0);
    repeat (4) @(negedge clk);
    got_q.push_back(got);
    ->got_ev;
  endtask

  // monitor: pair observed words with expected ones
  initial forever begin
    logic [RW-1:0] g;
    @(got_ev);
    while (got_q.size() > 0) begin
      g = got_q.pop_front();
      if (exp_q.size() == 0) chk("R5 unexpected word", 1, 0);
      else chk("R5 result word", g, exp_q.pop_front());
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    chk("R9 eoc in reset", eoc_n, 1);
    chk("R9 sample in reset", sample_o, 0);
    chk("R9 dac in reset", {dac_code, dac_fine}, 0);
    chk("R8 oe with cs high", dout_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    conv_n = 1'b0;
    repeat (2) @(negedge clk);
    conv_n = 1'b1;
    bad = 0;
    for (int k = 0; k < CAL; k++) begin
      @(negedge clk);
      if (sample_o || !eoc_n) bad++;
    end
    chk("R9 start ignored in calibration", bad, 0);

    convert(16'h1235, 2'b01, 2'b01); readout();
    convert(16'hFFFF, 2'b01, 2'b01); readout();
    convert(16'h0002, 2'b01, 2'b01); readout();
    convert(16'h0001, 2'b01, 2'b01); readout();
    convert(16'hA5C3, 2'b01, 2'b01); readout();
    // R8: second read of the same result restarts at MSB
    exp_q.push_back(last_exp); readout();

    // R10: power-down refuses starts, result and eoc kept
    for (int m = 0; m < 2; m++) begin
      mode = (m == 0) ? 2'b00 : 2'b11;
      @(negedge clk);
      chk("R10 sleep shown", sleep_o, 1);
      conv_n = 1'b0;
      repeat (2) @(negedge clk);
      conv_n = 1'b1;
      bad = 0;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk);
        if (sample_o || eoc_n) bad++;
      end
      chk("R10 start refused", bad, 0);
    end
    exp_q.push_back(last_exp); readout();

    // R11: bipolar captured, mode change mid-conversion has no effect
    convert(16'h8000, 2'b10, 2'b01);
    chk("R11 range after finish", range_bip, 1);
    readout();
    convert(16'h7FFD, 2'b01, 2'b10);
    chk("R11 unipolar after finish", range_bip, 0);
    readout();

    // R9: reset during a conversion stops it
    mode = 2'b01;
    vin = 16'h4444;
    @(negedge clk) conv_n = 1'b0;
    @(negedge clk) conv_n = 1'b1;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 eoc on reset", eoc_n, 1);
    chk("R9 dac cleared", {dac_code, dac_fine}, 0);
    chk("R9 sample cleared", sample_o, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (CAL + 6) @(negedge clk);
    chk("R9 idle after calibration", eoc_n, 1);
    convert(16'h0000, 2'b01, 2'b01); readout();

    repeat (10) @(negedge clk);
    fin = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule